// File: doc/BRIEF.md
# Posted Write Command Selector

This block lives on the master side of a bridge and decides how data from the posted write queue is delivered on the target bus. It looks at the queue and nothing else: its occupancy, the address of the head Dword, the byte enables and end-of-transaction marks of each queued Dword, the write-and-invalidate enable, the target cache line size and the flow-through flag. From these it decides when a burst starts and which command it uses. A burst uses memory write and invalidate (MWI) when every condition for it holds, and plain memory write otherwise. The command the originator used does not enter the decision, so an incoming plain write can go out as MWI, and an incoming MWI can go out as a plain write.

Once a burst is running, the block holds its command constant. It pulses a per-Dword transfer strobe while the stand-in bus is ready, and raises a termination flag on the final data phase. An MWI burst covers only the run of complete, fully enabled, aligned cache lines at the head of the queue. Whatever follows goes out later as a plain write. In flow-through mode a burst also closes when the queue drains, and a new one waits until a whole cache line has built up.

Top module: `pw_cmd_select`

## Requirements
- R1: While `rst_n` is low, `start_o`, `active_o`, `cmd_mwi_o`, `xfer_o` and `term_o` are all 0.
- R2: With `mwi_en` low every burst uses memory write (`cmd_mwi_o` = 0), however the queued data looks.
- R3: `cls` counts Dwords. Only 8, 16 and 32 are valid line sizes. Any other value (for example 12 or 64) forces memory write.
- R4: MWI is chosen only if `head_addr` is a multiple of the line size and at least one complete line is queued. A misaligned head, or fewer Dwords than a line, gives memory write.
- R5: MWI needs all four byte enables active for every Dword of the line. Entry i counted from the head uses `q_be[4i+3:4i]`. One missing byte in a line excludes that line.
- R6: When R2 to R5 all hold, the burst is MWI. It covers the consecutive complete, fully enabled lines at the head and ends on a line boundary. A Dword marked last may close it only at a line end. The rest of the data follows as a separate memory write burst.
- R7: Outside flow-through mode a burst starts only once a Dword marked last (`q_last[i]`) is queued. A memory write burst ends on the transfer of the head Dword marked last.
- R8: In flow-through mode a burst also starts once `q_count` reaches the line size, or 8 when `cls` is invalid. The burst ends on the transfer that empties the queue. A new burst waits for that threshold again.
- R9: `start_o` is a one-cycle pulse in the first active cycle. `cmd_mwi_o` stays constant from start until termination, even if `mwi_en` changes.
- R10: `xfer_o` is high only while active, `bus_ready` is high and the queue is non-empty. `term_o` coincides with the final `xfer_o` and is followed by an inactive cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_count | input | CNT_W | Number of Dwords in the posted write queue |
| head_addr | input | ADDR_W | Dword address (low bits) of the head entry |
| q_be | input | 4*DEPTH | Byte enables, four bits per entry, entry 0 is the head |
| q_last | input | DEPTH | End-of-transaction mark per entry |
| mwi_en | input | 1 | Write-and-invalidate enable for the target interface |
| cls | input | 8 | Target cache line size in Dwords |
| flow_mode | input | 1 | Flow-through mode |
| bus_ready | input | 1 | Target bus accepts a data phase this cycle |
| start_o | output | 1 | One-cycle pulse at the start of a burst |
| cmd_mwi_o | output | 1 | 1 = MWI, 0 = memory write, held for the burst |
| active_o | output | 1 | A burst is in progress |
| xfer_o | output | 1 | Data phase completes; the queue pops its head |
| term_o | output | 1 | This data phase is the last of the burst |

## Verification
A corrupted line-length counter shows as an MWI burst that stops short of, or runs past, a line boundary. This appears on the transfer where the boundary falls, at most 32 data phases after the start. A command bit that flips mid-burst shows on `cmd_mwi_o` in the very next cycle. A lost active flag shows as a `term_o` that never arrives, or as an extra `start_o` pulse, and in both cases the bench's burst list differs from the expected one within the same scenario. The tests compare complete burst sequences (command and length per burst) so that a fault in start, command or termination logic changes a visible count.

// File: rtl/pwcs_pkg.sv
package pwcs_pkg;

    typedef enum logic {
        CMD_MW  = 1'b0,
        CMD_MWI = 1'b1
    } wr_cmd_e;

    // Dwords per line for a valid size code, 0 when the code is unusable
    function automatic logic [5:0] line_dwords(input logic [7:0] code);
        case (code)
            8'd8:    line_dwords = 6'd8;
            8'd16:   line_dwords = 6'd16;
            8'd32:   line_dwords = 6'd32;
            default: line_dwords = 6'd0;
        endcase
    endfunction

endpackage

// File: rtl/pwcs_cls_decode.sv
module pwcs_cls_decode #(
    parameter int CNT_W      = 7,
    parameter int FT_DEFAULT = 8
) (
    input  logic [7:0]       cls,
    output logic             cls_ok,
    output logic [CNT_W-1:0] line_len
);
    import pwcs_pkg::*;

    logic [5:0] dw;

    always_comb begin
        dw       = line_dwords(cls);
        cls_ok   = (dw != 6'd0);
        line_len = cls_ok ? CNT_W'(dw) : CNT_W'(FT_DEFAULT);
    end

endmodule

// File: rtl/pwcs_line_scan.sv
module pwcs_line_scan #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0]   q_count,
    input  logic [4*DEPTH-1:0] q_be,
    input  logic [DEPTH-1:0]   q_last,
    input  logic [CNT_W-1:0]   line_len,
    output logic [CNT_W-1:0]   mwi_words,
    output logic               last_seen
);
    logic [CNT_W-1:0] line_mask;
    logic [CNT_W-1:0] prefix;

    assign line_mask = line_len - CNT_W'(1);

    always_comb begin
        logic run;
        logic present;
        logic ok;
        run       = 1'b1;
        prefix    = '0;
        last_seen = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            present = (CNT_W'(i) < q_count);
            ok      = present && (&q_be[4*i +: 4]) &&
                      (!q_last[i] || ((CNT_W'(i + 1) & line_mask) == '0));
            if (run && ok) prefix = CNT_W'(i + 1);
            else           run    = 1'b0;
            if (present && q_last[i]) begin
                last_seen = 1'b1;
                run       = 1'b0;
            end
        end
        mwi_words = prefix & ~line_mask;
    end

endmodule

// File: rtl/pw_cmd_select.sv
module pw_cmd_select #(
    parameter int DEPTH      = 64,
    parameter int ADDR_W     = 6,
    parameter int FT_DEFAULT = 8,
    parameter int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    q_count,
    input  logic [ADDR_W-1:0]   head_addr,
    input  logic [4*DEPTH-1:0]  q_be,
    input  logic [DEPTH-1:0]    q_last,
    input  logic                mwi_en,
    input  logic [7:0]          cls,
    input  logic                flow_mode,
    input  logic                bus_ready,
    output logic                start_o,
    output logic                cmd_mwi_o,
    output logic                active_o,
    output logic                xfer_o,
    output logic                term_o
);
    import pwcs_pkg::*;

    typedef struct packed {
        logic             active;
        logic             start;
        wr_cmd_e          cmd;
        logic [CNT_W-1:0] rem;
    } sel_t;

    sel_t s_d, s_q;

    logic             cls_ok;
    logic [CNT_W-1:0] line_len;
    logic [CNT_W-1:0] mwi_words;
    logic             last_seen;
    logic             aligned;
    logic             mwi_ok;
    logic             go;
    logic             xfer;
    logic             final_w;

    pwcs_cls_decode #(
        .CNT_W      (CNT_W),
        .FT_DEFAULT (FT_DEFAULT)
    ) u_dec (
        .cls      (cls),
        .cls_ok   (cls_ok),
        .line_len (line_len)
    );

    pwcs_line_scan #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_scan (
        .q_count   (q_count),
        .q_be      (q_be),
        .q_last    (q_last),
        .line_len  (line_len),
        .mwi_words (mwi_words),
        .last_seen (last_seen)
    );

    always_comb begin
        aligned = (head_addr & ADDR_W'(line_len - CNT_W'(1))) == '0;
        mwi_ok  = mwi_en && cls_ok && aligned && (mwi_words != '0);
        go      = (q_count != '0) &&
                  (last_seen || (flow_mode && (q_count >= line_len)));
        xfer    = s_q.active && bus_ready && (q_count != '0);
        final_w = (s_q.cmd == CMD_MWI) ? (s_q.rem == CNT_W'(1))
                                       : (q_last[0] || (flow_mode && (q_count == CNT_W'(1))));

        s_d       = s_q;
        s_d.start = 1'b0;
        if (!s_q.active) begin
            if (go) begin
                s_d.active = 1'b1;
                s_d.start  = 1'b1;
                s_d.cmd    = mwi_ok ? CMD_MWI : CMD_MW;
                s_d.rem    = mwi_words;
            end
        end else if (xfer) begin
            s_d.rem = s_q.rem - CNT_W'(1);
            if (final_w) begin
                s_d.active = 1'b0;
                s_d.cmd    = CMD_MW;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start_o   = s_q.start;
    assign cmd_mwi_o = (s_q.cmd == CMD_MWI);
    assign active_o  = s_q.active;
    assign xfer_o    = xfer;
    assign term_o    = xfer && final_w;

    // R9
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !s_q.start) |-> $stable(s_q.cmd));

    // R9
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R2 R3
    mwi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.active) && (s_q.cmd == CMD_MWI)) |-> ($past(mwi_en) && $past(cls_ok)));

    // R6
    mwi_line_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term_o && cmd_mwi_o) |->
            (((head_addr + ADDR_W'(1)) & ADDR_W'(line_len - CNT_W'(1))) == '0));

    // R10
    term_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_o |=> !active_o);

endmodule

// File: tb/pw_cmd_select_tb.sv
module pw_cmd_select_tb_top;
    localparam int DEPTH  = 64;
    localparam int ADDR_W = 6;
    localparam int CNT_W  = 7;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                rst_n;
    logic [CNT_W-1:0]    q_count;
    logic [ADDR_W-1:0]   head_addr;
    logic [4*DEPTH-1:0]  q_be;
    logic [DEPTH-1:0]    q_last;
    logic                mwi_en;
    logic [7:0]          cls;
    logic                flow_mode;
    logic                bus_ready;
    logic start_o, cmd_mwi_o, active_o, xfer_o, term_o;

    logic [3:0] m_be   [DEPTH];
    logic       m_last [DEPTH];
    int         m_cnt;

    int n_chk = 0, n_err = 0;
    logic pend;
    logic done = 1'b0;
    int starts, nb, cur_len;
    logic cur_cmd;
    logic b_cmd [16];
    int   b_len [16];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            q_be[4*i +: 4] = (i < m_cnt) ? m_be[i] : 4'h0;
            q_last[i]      = (i < m_cnt) ? m_last[i] : 1'b0;
        end
        q_count = CNT_W'(m_cnt);
    end

    pw_cmd_select #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .q_count(q_count), .head_addr(head_addr),
        .q_be(q_be), .q_last(q_last), .mwi_en(mwi_en), .cls(cls),
        .flow_mode(flow_mode), .bus_ready(bus_ready), .start_o(start_o),
        .cmd_mwi_o(cmd_mwi_o), .active_o(active_o), .xfer_o(xfer_o), .term_o(term_o));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] be, input logic last);
        m_be[m_cnt] = be; m_last[m_cnt] = last; m_cnt++;
    endtask

    task automatic fill(input int n, input logic last_end);
        for (int i = 0; i < n; i++) push(4'hF, last_end && (i == n - 1));
    endtask

    task automatic pop();
        for (int i = 0; i < DEPTH - 1; i++) begin
            m_be[i] = m_be[i+1]; m_last[i] = m_last[i+1];
        end
        m_cnt--;
        head_addr = head_addr + ADDR_W'(1);
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        if (pend) pop();
        pend = 1'b0;
        #1;
        if (start_o) starts++;
        if (xfer_o) begin
            cur_len++;
            cur_cmd = cmd_mwi_o;
            if (term_o) begin
                b_cmd[nb] = cur_cmd; b_len[nb] = cur_len; nb++; cur_len = 0;
            end
        end
        pend = xfer_o;
    endtask

    task automatic drain();
        int n = 0;
        do begin step(); n++; end
        while ((m_cnt != 0 || active_o || pend) && n < 300);
    endtask

    task automatic clear_log(input logic [ADDR_W-1:0] addr);
        nb = 0; cur_len = 0; starts = 0; head_addr = addr;
    endtask

    task automatic expect_burst(input string tag, input int k, input logic c, input int len);
        chk({tag, " cmd"}, (nb > k) ? int'(b_cmd[k]) : -1, int'(c));
        chk({tag, " len"}, (nb > k) ? b_len[k] : -1, len);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        m_cnt = 0; pend = 1'b0; mwi_en = 1'b1; cls = 8'd8; flow_mode = 1'b0; bus_ready = 1'b1;
        clear_log('0);
        fill(8, 1'b1);
        repeat (3) step();
        chk("R1 start", int'(start_o), 0);
        chk("R1 active", int'(active_o), 0);
        chk("R1 xfer/term", int'(xfer_o | term_o | cmd_mwi_o), 0);
        m_cnt = 0;
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_mwi_disabled();
        mwi_en = 1'b0; cls = 8'd8; clear_log('0);
        fill(8, 1'b1); drain();
        chk("R2 bursts", nb, 1);
        expect_burst("R2", 0, 1'b0, 8);
        mwi_en = 1'b1;
    endtask

    task automatic t_cls_sizes();
        cls = 8'd12; clear_log('0); fill(8, 1'b1); drain();
        expect_burst("R3 cls12", 0, 1'b0, 8);
        cls = 8'd64; clear_log('0); fill(8, 1'b1); drain();
        expect_burst("R3 cls64", 0, 1'b0, 8);
        cls = 8'd16; clear_log('0); fill(16, 1'b1); drain();
        expect_burst("R3 cls16", 0, 1'b1, 16);
        cls = 8'd32; clear_log('0); fill(32, 1'b1); drain();
        expect_burst("R3 cls32", 0, 1'b1, 32);
        cls = 8'd8;
    endtask

    task automatic t_alignment();
        clear_log(ADDR_W'(4)); fill(12, 1'b1); drain();
        chk("R4 misaligned bursts", nb, 1);
        expect_burst("R4 misaligned", 0, 1'b0, 12);
        clear_log('0); fill(6, 1'b1); drain();
        expect_burst("R4 short", 0, 1'b0, 6);
    endtask

    task automatic t_byte_enables();
        clear_log('0);
        fill(3, 1'b0); push(4'b1011, 1'b0); fill(4, 1'b1); drain();
        chk("R5 one line bursts", nb, 1);
        expect_burst("R5 one line", 0, 1'b0, 8);
        clear_log('0);
        fill(10, 1'b0); push(4'b0111, 1'b0); fill(5, 1'b1); drain();
        chk("R5 two line bursts", nb, 2);
        expect_burst("R5 first", 0, 1'b1, 8);
        expect_burst("R5 second", 1, 1'b0, 8);
    endtask

    task automatic t_promote();
        clear_log('0); fill(20, 1'b1); drain();
        chk("R6 bursts", nb, 2);
        chk("R6 starts", starts, 2);
        expect_burst("R6 lines", 0, 1'b1, 16);
        expect_burst("R6 remainder", 1, 1'b0, 4);
    endtask

    task automatic t_nonflow();
        mwi_en = 1'b0; clear_log('0);
        fill(5, 1'b0);
        repeat (10) step();
        chk("R7 no start without last", starts, 0);
        push(4'hF, 1'b1); drain();
        expect_burst("R7 whole", 0, 1'b0, 6);
        clear_log('0);
        fill(3, 1'b1); fill(4, 1'b1); drain();
        chk("R7 split bursts", nb, 2);
        expect_burst("R7 first", 0, 1'b0, 3);
        expect_burst("R7 second", 1, 1'b0, 4);
        mwi_en = 1'b1;
    endtask

    task automatic t_flow();
        mwi_en = 1'b0; flow_mode = 1'b1; clear_log('0);
        fill(3, 1'b0);
        repeat (6) step();
        chk("R8 below threshold", starts, 0);
        fill(5, 1'b0); drain();
        chk("R8 bursts", nb, 1);
        expect_burst("R8 empty end", 0, 1'b0, 8);
        fill(4, 1'b0);
        repeat (6) step();
        chk("R8 no restart", starts, 1);
        fill(4, 1'b0); drain();
        chk("R8 restart", starts, 2);
        expect_burst("R8 second", 1, 1'b0, 8);
        flow_mode = 1'b0; mwi_en = 1'b1;
    endtask

    task automatic t_cmd_hold();
        int n = 0;
        clear_log('0); fill(16, 1'b1);
        do begin step(); n++; end while (!start_o && n < 20);
        chk("R9 start cmd", int'(cmd_mwi_o), 1);
        mwi_en = 1'b0;
        drain();
        chk("R9 single start", starts, 1);
        expect_burst("R9 held", 0, 1'b1, 16);
        mwi_en = 1'b1;
    endtask

    task automatic t_stall();
        mwi_en = 1'b0; bus_ready = 1'b0; clear_log('0);
        fill(8, 1'b1);
        repeat (5) step();
        chk("R10 active stalled", int'(active_o), 1);
        chk("R10 no xfer", int'(xfer_o | term_o), 0);
        chk("R10 queue kept", m_cnt, 8);
        bus_ready = 1'b1; drain();
        expect_burst("R10 resumed", 0, 1'b0, 8);
        mwi_en = 1'b1;
    endtask

    initial begin
        head_addr = '0;
        t_reset();
        t_mwi_disabled();
        t_cls_sizes();
        t_alignment();
        t_byte_enables();
        t_promote();
        t_nonflow();
        t_flow();
        t_cmd_hold();
        t_stall();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule